// File: doc/BRIEF.md
# Front-End State Shadow Register File

This block sits at the head of a graphics pipeline and keeps a shadow copy of every packed state word it has sent downstream. Each word gathers several unrelated configuration fields into 32 bits. A configuration method names one entry and a field in it (bit offset, width, value). The block merges the new field into the stored word and sends the whole updated word down the pipeline as a state bundle, tagged with the entry number as its bundle type.

A simple register bus gives direct access to the same storage. Reads return the stored word and cause no traffic downstream, so a context save is a sweep of reads. A bus write replaces a whole entry and emits it as a bundle, so a context restore is a sweep of writes that brings every downstream unit back to its saved state.

The bundle output is a valid/ready stream with a single output register. A bundle that is offered stays offered, unchanged, until the consumer takes it. While the offered bundle is not taken, the block refuses new methods and bus writes through their ready pins, so no update is lost. When a bundle is taken, a new update can be accepted in the same cycle. Bus reads are never refused.

Top module: `fe_state_shadow`

## Requirements
- R1: After reset every entry reads 0 and no bundle is offered (`bnd_valid` low).
- R2: An accepted method sets entry `mth_type` to `(old & ~mask) | ((mth_value << mth_offset) & mask)`. `mask` covers bits `mth_offset` to `mth_offset+mth_width-1`, clipped at bit 31. A width of 0 leaves the word unchanged.
- R3: In the cycle after an accepted method or bus write, `bnd_valid` is high. `bnd_type` carries the entry number and `bnd_data` the complete new contents of the entry.
- R4: Methods accepted in consecutive cycles on the same entry each merge against the value left by the one before.
- R5: An accepted bus write (`bus_wr_en` with `bus_wr_ready`) replaces entry `bus_addr` with `bus_wdata` and emits it as a bundle.
- R6: A bus read (`bus_rd_en`) returns the entry in `bus_rdata` one cycle later with `bus_rd_valid` high. It returns the value held before any write accepted in the same cycle, and it never emits a bundle.
- R7: While `bnd_valid` is high and `bnd_ready` is low, `bnd_valid`, `bnd_type` and `bnd_data` hold steady, and `mth_ready` and `bus_wr_ready` are low. When `bnd_ready` rises, a new update is accepted in that same cycle.
- R8: A bus write takes precedence over a method in the same cycle. `mth_ready` is low whenever `bus_wr_en` is high, and the held method is accepted afterwards, merged against the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mth_valid | input | 1 | Method update offered |
| mth_ready | output | 1 | Method update accepted this cycle when high with mth_valid |
| mth_type | input | TYPE_W | Entry the method updates |
| mth_offset | input | 5 | Lowest bit of the field |
| mth_width | input | 6 | Field width, 0 to 32 |
| mth_value | input | 32 | Field value, right-aligned |
| bus_wr_en | input | 1 | Register-bus write request |
| bus_wr_ready | output | 1 | Register-bus write accepted when high with bus_wr_en |
| bus_rd_en | input | 1 | Register-bus read request |
| bus_addr | input | TYPE_W | Register-bus entry address |
| bus_wdata | input | 32 | Register-bus write data |
| bus_rd_valid | output | 1 | Read data valid, one cycle after bus_rd_en |
| bus_rdata | output | 32 | Read data |
| bnd_valid | output | 1 | Bundle offered |
| bnd_ready | input | 1 | Downstream takes the bundle |
| bnd_type | output | TYPE_W | Bundle type (entry number) |
| bnd_data | output | 32 | Bundle word |

## Verification
Two pairs of functions can fall in the same cycle. The first is a bus write and a method. The bench raises both in one cycle on the same entry. It checks that the method is refused, that the written word goes out first, and that the method then goes out merged onto the written value. The second is a bus read and a bus write to the same address. The bench issues both in one cycle and checks that the read returns the old word while the bundle carries the new one. A third overlap comes from back-pressure: a queued method is accepted in the same cycle that the stalled bundle is released, and the bench checks that both words come out in order.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = $clog2(WORD_W);
  localparam int WID_W  = OFS_W + 1;
  localparam int SPAN_W = OFS_W + 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [WID_W-1:0]  wid_t;
endpackage

// File: rtl/fss_field_merge.sv
module fss_field_merge
  import fss_pkg::*;
(
  input  word_t old_word,
  input  ofs_t  offset,
  input  wid_t  width,
  input  word_t value,
  output word_t merged
);
  logic [SPAN_W-1:0] lo_bit;
  logic [SPAN_W-1:0] hi_bit;
  word_t mask;
  word_t shifted;

  assign lo_bit  = SPAN_W'(offset);
  assign hi_bit  = SPAN_W'(offset) + SPAN_W'(width);
  assign shifted = value << offset;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    localparam logic [SPAN_W-1:0] BIT_IDX = SPAN_W'(b);
    assign mask[b] = (BIT_IDX >= lo_bit) && (BIT_IDX < hi_bit);
  end

  assign merged = (old_word & ~mask) | (shifted & mask);
endmodule

// File: rtl/fss_shadow_bank.sv
module fss_shadow_bank
  import fss_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int TYPE_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TYPE_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic [TYPE_W-1:0] mrg_addr,
  output word_t             mrg_data,
  input  logic              rd_en,
  input  logic [TYPE_W-1:0] rd_addr,
  output logic              rd_valid,
  output word_t             rd_data
);
  word_t entry_q [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[e] <= '0;
      end else if (wr_en && (wr_addr == TYPE_W'(e))) begin
        entry_q[e] <= wr_data;
      end
    end
  end

  assign mrg_data = entry_q[mrg_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= entry_q[rd_addr];
      end
    end
  end
endmodule

// File: rtl/fss_bundle_slot.sv
module fss_bundle_slot
  import fss_pkg::*;
#(
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TYPE_W-1:0] load_type,
  input  word_t             load_data,
  output logic              can_load,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TYPE_W-1:0] out_type,
  output word_t             out_data
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_type  <= '0;
      out_data  <= '0;
    end else if (can_load) begin
      out_valid <= load;
      if (load) begin
        out_type <= load_type;
        out_data <= load_data;
      end
    end
  end
endmodule

// File: rtl/fe_state_shadow.sv
module fe_state_shadow
  import fss_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int TYPE_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mth_valid,
  output logic              mth_ready,
  input  logic [TYPE_W-1:0] mth_type,
  input  logic [4:0]        mth_offset,
  input  logic [5:0]        mth_width,
  input  logic [31:0]       mth_value,
  input  logic              bus_wr_en,
  output logic              bus_wr_ready,
  input  logic              bus_rd_en,
  input  logic [TYPE_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rd_valid,
  output logic [31:0]       bus_rdata,
  output logic              bnd_valid,
  input  logic              bnd_ready,
  output logic [TYPE_W-1:0] bnd_type,
  output logic [31:0]       bnd_data
);
  logic              slot_free;
  logic              take_bus;
  logic              take_mth;
  logic              upd_en;
  logic [TYPE_W-1:0] upd_addr;
  word_t             upd_data;
  word_t             cur_word;
  word_t             merged_word;

  // Bus writes win; methods only proceed on a free slot with no bus write.
  assign take_bus     = bus_wr_en && slot_free;
  assign take_mth     = mth_valid && slot_free && !bus_wr_en;
  assign bus_wr_ready = slot_free;
  assign mth_ready    = slot_free && !bus_wr_en;

  assign upd_en   = take_bus || take_mth;
  assign upd_addr = take_bus ? bus_addr : mth_type;
  assign upd_data = take_bus ? bus_wdata : merged_word;

  fss_shadow_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (upd_en),
    .wr_addr  (upd_addr),
    .wr_data  (upd_data),
    .mrg_addr (mth_type),
    .mrg_data (cur_word),
    .rd_en    (bus_rd_en),
    .rd_addr  (bus_addr),
    .rd_valid (bus_rd_valid),
    .rd_data  (bus_rdata)
  );

  fss_field_merge u_merge (
    .old_word (cur_word),
    .offset   (mth_offset),
    .width    (mth_width),
    .value    (mth_value),
    .merged   (merged_word)
  );

  fss_bundle_slot #(.TYPE_W(TYPE_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (upd_en),
    .load_type (upd_addr),
    .load_data (upd_data),
    .can_load  (slot_free),
    .out_valid (bnd_valid),
    .out_ready (bnd_ready),
    .out_type  (bnd_type),
    .out_data  (bnd_data)
  );
endmodule

// File: rtl/fe_state_shadow_chk.sv
module fe_state_shadow_chk #(
  parameter int NUM_ENTRIES = 8,
  localparam int TYPE_W = $clog2(NUM_ENTRIES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mth_valid,
  input logic              mth_ready,
  input logic              bus_wr_en,
  input logic              bus_wr_ready,
  input logic              bus_rd_en,
  input logic [TYPE_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd_valid,
  input logic              bnd_valid,
  input logic              bnd_ready,
  input logic [TYPE_W-1:0] bnd_type,
  input logic [31:0]       bnd_data
);
  AST_BND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_valid && !bnd_ready |=> bnd_valid && $stable(bnd_type) && $stable(bnd_data)); // R7
  AST_STALL_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_valid && !bnd_ready |-> !mth_ready && !bus_wr_ready); // R7
  AST_BUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |-> !mth_ready); // R8
  AST_EMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mth_valid && mth_ready) || (bus_wr_en && bus_wr_ready) |=> bnd_valid); // R3
  AST_BUS_WR_BUNDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && bus_wr_ready |=> bnd_type == $past(bus_addr) && bnd_data == $past(bus_wdata)); // R5
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rd_valid); // R6
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en && !bus_wr_en && !mth_valid && !(bnd_valid && !bnd_ready) |=> !bnd_valid); // R6
endmodule

bind fe_state_shadow fe_state_shadow_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mth_valid    (mth_valid),
  .mth_ready    (mth_ready),
  .bus_wr_en    (bus_wr_en),
  .bus_wr_ready (bus_wr_ready),
  .bus_rd_en    (bus_rd_en),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rd_valid (bus_rd_valid),
  .bnd_valid    (bnd_valid),
  .bnd_ready    (bnd_ready),
  .bnd_type     (bnd_type),
  .bnd_data     (bnd_data)
);

// File: tb/fe_state_shadow_bench.sv
`timescale 1ns/1ps
module fe_state_shadow_bench;
  localparam int N  = 8;
  localparam int TW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mth_valid = 1'b0;
  logic          mth_ready;
  logic [TW-1:0] mth_type = '0;
  logic [4:0]    mth_offset = '0;
  logic [5:0]    mth_width = '0;
  logic [31:0]   mth_value = '0;
  logic          bus_wr_en = 1'b0;
  logic          bus_wr_ready;
  logic          bus_rd_en = 1'b0;
  logic [TW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd_valid;
  logic [31:0]   bus_rdata;
  logic          bnd_valid;
  logic          bnd_ready = 1'b1;
  logic [TW-1:0] bnd_type;
  logic [31:0]   bnd_data;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  logic [31:0] model [N];

  always #5 clk = ~clk;

  fe_state_shadow #(.NUM_ENTRIES(N)) u_fe_state_shadow (
    .clk(clk), .rst_n(rst_n),
    .mth_valid(mth_valid), .mth_ready(mth_ready), .mth_type(mth_type),
    .mth_offset(mth_offset), .mth_width(mth_width), .mth_value(mth_value),
    .bus_wr_en(bus_wr_en), .bus_wr_ready(bus_wr_ready), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd_valid(bus_rd_valid),
    .bus_rdata(bus_rdata), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
    .bnd_type(bnd_type), .bnd_data(bnd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input int off,
                                        input int w, input logic [31:0] v);
    logic [63:0] m;
    m = ((64'd1 << w) - 64'd1) << off;
    return (old & ~m[31:0]) | ((v << off) & m[31:0]);
  endfunction

  task automatic emit_chk(input string req, input int t, input logic [31:0] d);
    chk({req, " valid"}, 32'(bnd_valid), 32'd1);
    chk({req, " type"}, 32'(bnd_type), 32'(t));
    chk({req, " data"}, bnd_data, d);
  endtask

  task automatic method(input int t, input int off, input int w, input logic [31:0] v);
    @(negedge clk);
    mth_valid = 1'b1; mth_type = TW'(t);
    mth_offset = 5'(off); mth_width = 6'(w); mth_value = v;
    @(negedge clk);
    mth_valid = 1'b0;
    model[t] = merge(model[t], off, w, v);
    emit_chk("R2", t, model[t]);
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = TW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
    model[a] = d;
    emit_chk("R5", a, d);
  endtask

  task automatic bus_read(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = TW'(a);
    @(negedge clk);
    bus_rd_en = 1'b0;
    chk({req, " rd_valid"}, 32'(bus_rd_valid), 32'd1);
    chk({req, " rdata"}, bus_rdata, exp);
    chk("R6 read emits nothing", 32'(bnd_valid), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 bnd_valid", 32'(bnd_valid), 32'd0);
    for (int i = 0; i < N; i++) bus_read("R1", i, 32'd0);

    // R2/R3: sweep every offset and width over rotating entries
    for (int off = 0; off < 32; off++) begin
      for (int w = 0; w <= 32; w++) begin
        method((off + w) % N, off, w,
               32'hA5C3_0F96 ^ (32'(off * 37 + w) * 32'h0101_0101));
      end
    end
    for (int i = 0; i < N; i++) bus_read("R2 sweep readback", i, model[i]);

    // R4: back-to-back updates to one entry
    @(negedge clk);
    mth_valid = 1'b1; mth_type = 3'd2; mth_offset = 5'd0; mth_width = 6'd8; mth_value = 32'h11;
    @(negedge clk);
    model[2] = merge(model[2], 0, 8, 32'h11);
    emit_chk("R4 first", 2, model[2]);
    mth_offset = 5'd8; mth_value = 32'h22;
    @(negedge clk);
    model[2] = merge(model[2], 8, 8, 32'h22);
    emit_chk("R4 second", 2, model[2]);
    mth_offset = 5'd4; mth_width = 6'd8; mth_value = 32'h3C;
    @(negedge clk);
    mth_valid = 1'b0;
    model[2] = merge(model[2], 4, 8, 32'h3C);
    emit_chk("R4 third", 2, model[2]);

    // R7: back-pressure holds the bundle and stalls both inputs
    @(negedge clk);
    bnd_ready = 1'b0;
    mth_valid = 1'b1; mth_type = 3'd3; mth_offset = 5'd16; mth_width = 6'd4; mth_value = 32'h9;
    @(negedge clk);
    model[3] = merge(model[3], 16, 4, 32'h9);
    emit_chk("R7 held", 3, model[3]);
    mth_type = 3'd4; mth_offset = 5'd0; mth_width = 6'd32; mth_value = 32'hDEAD_BEEF;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R7 mth_ready low", 32'(mth_ready), 32'd0);
      chk("R7 bus_wr_ready low", 32'(bus_wr_ready), 32'd0);
      @(negedge clk);
      emit_chk("R7 stable", 3, model[3]);
    end
    bnd_ready = 1'b1;
    #1 chk("R7 accept on release", 32'(mth_ready), 32'd1);
    @(negedge clk);
    mth_valid = 1'b0;
    model[4] = 32'hDEAD_BEEF;
    emit_chk("R7 next", 4, model[4]);
    @(negedge clk);
    chk("R7 drained", 32'(bnd_valid), 32'd0);

    // R8: bus write and method on one entry in the same cycle
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h1234_5678;
    mth_valid = 1'b1; mth_type = 3'd5; mth_offset = 5'd4; mth_width = 6'd4; mth_value = 32'hF;
    #1 chk("R8 mth_ready low", 32'(mth_ready), 32'd0);
    @(negedge clk);
    bus_wr_en = 1'b0;
    model[5] = 32'h1234_5678;
    emit_chk("R8 bus first", 5, model[5]);
    @(negedge clk);
    mth_valid = 1'b0;
    model[5] = merge(model[5], 4, 4, 32'hF);
    emit_chk("R8 method after", 5, model[5]);

    // R6: read and write to one address in the same cycle
    @(negedge clk);
    bus_wr_en = 1'b1; bus_rd_en = 1'b1; bus_addr = 3'd6; bus_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    chk("R6 old value", bus_rdata, model[6]);
    model[6] = 32'hCAFE_F00D;
    emit_chk("R6 write bundle", 6, model[6]);
    bus_read("R6", 6, model[6]);

    // R5: restore all entries, then save them back
    for (int i = 0; i < N; i++) bus_write(i, 32'h0F0F_0000 + 32'(i * 257));
    for (int i = 0; i < N; i++) bus_read("R5 save", i, model[i]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule